// File: doc/BRIEF.md
# UART Channel Mode Data Router

This block sits between the serial line logic of a UART and its two character FIFOs. A 2-bit channel mode decides where characters go. A byte from the receive deserializer can go to the receive FIFO, to the transmit FIFO, to both, or nowhere. A host write to the data register can go to the transmit FIFO, to the receive FIFO, or nowhere. This gives normal operation, automatic echo, local loopback and remote loopback without changing the datapath.

A control register holds an enable/disable bit pair for each direction, so each path can be switched on and off. It also has self-clearing bits that empty either FIFO. Other rules:
- A detected line break enters the receive FIFO as a zero byte.
- A push into a full FIFO is dropped and flagged as an overflow.
- A host read pops the receive FIFO.
- A receive-timeout counter, clocked by bit strobes, fires after four character times with no new accepted byte.

The FIFOs themselves sit outside this block. It drives their push, pop and flush strobes and reads their full, empty and head-data signals. The receive FIFO must present its oldest entry on its read-data output (first-word fall-through).

Top module: `uart_chan_router`

## Requirements
- R1: After reset the control register reads 0x128. Both paths are then inactive, so no push, pop or overflow occurs.
- R2: Line byte routing by `chan_mode`:
  - 0 (normal): the receive FIFO only.
  - 1 (echo): both FIFOs.
  - 2 (local loopback): neither FIFO.
  - 3 (remote loopback): the transmit FIFO only.
  - The push is in the same cycle as `line_rx_vld`.
- R3: Host data-register write routing:
  - Mode 0: the transmit FIFO.
  - Mode 2: the receive FIFO.
  - Modes 1 and 3: dropped.
  - The push is in the same cycle as `host_wr`.
- R4: Path gating from control bits:
  - The receive path is active only while bit 2 is 1 and bit 3 is 0.
  - The transmit path is active only while bit 4 is 1 and bit 5 is 0.
  - An inactive path makes no push and raises no overflow.
- R5: Writing control bit 0 or bit 1 pulses `rxf_flush` or `txf_flush`, respectively, for the one cycle after the write edge. Both bits read back as 0.
- R6: A receive-path byte offered while `rxf_full` is 1 is not pushed, and `rx_ovr` is 1 in that cycle.
- R7: A transmit-path byte offered while `txf_full` is 1 is not pushed, and `tx_ovr` is 1 in that cycle.
- R8: Line breaks:
  - In every mode, `line_brk` pushes 0x00 into the receive FIFO, provided the receive path is active.
  - If a local-loopback host write arrives in the same cycle as a break, the break wins. The host byte is dropped and `rx_ovr` is raised.
- R9: Host reads:
  - A `host_rd` while the receive path is active and the FIFO is not empty pops the FIFO. `host_rdata` holds the head byte from the next cycle on.
  - Otherwise there is no pop, and `host_rdata` becomes 0.
- R10: Receive timeout:
  - `rx_timeout` pulses for one cycle after the N-th `bit_tick` that follows the last byte pushed into the receive FIFO.
  - N = 4 × (1 + data bits + parity bit + stop bits).
  - Data bits come from `len_sel`: 01 → 7, 10 → 6, 00 or 11 → 8.
  - Parity adds 1 when `par_en` is 1.
  - Stop bits are 2 when `stop2` is 1, and 1 otherwise.
  - Each newly accepted byte restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 9 | Control register write value |
| ctrl_q | output | 9 | Control register contents |
| chan_mode | input | 2 | Channel mode (0 normal, 1 echo, 2 local loop, 3 remote loop) |
| len_sel | input | 2 | Data length code |
| par_en | input | 1 | Parity bit present |
| stop2 | input | 1 | Two stop bits |
| line_rx_vld | input | 1 | Received byte strobe |
| line_rx_byte | input | 8 | Received byte |
| line_brk | input | 1 | Line break detected strobe |
| bit_tick | input | 1 | One strobe per bit time |
| host_wr | input | 1 | Host write to data register |
| host_wdata | input | 8 | Host write value |
| host_rd | input | 1 | Host read of data register |
| host_rdata | output | 8 | Host read value |
| rxf_push | output | 1 | Receive FIFO push |
| rxf_wdata | output | 8 | Receive FIFO push data |
| rxf_full | input | 1 | Receive FIFO full |
| rxf_pop | output | 1 | Receive FIFO pop |
| rxf_rdata | input | 8 | Receive FIFO head byte |
| rxf_empty | input | 1 | Receive FIFO empty |
| rxf_flush | output | 1 | Receive FIFO flush |
| txf_push | output | 1 | Transmit FIFO push |
| txf_wdata | output | 8 | Transmit FIFO push data |
| txf_full | input | 1 | Transmit FIFO full |
| txf_flush | output | 1 | Transmit FIFO flush |
| rx_ovr | output | 1 | Receive overflow event |
| tx_ovr | output | 1 | Transmit overflow event |
| rx_timeout | output | 1 | Receive timeout event |

## Verification
Results fall due at three different times after their stimulus:
- Pushes, overflow flags and pops are combinational, so they appear in the same cycle as the strobe that causes them.
- Control readback, flush pulses and read data come from registers, so they appear in the cycle after the clock edge that samples the strobe.
- The timeout pulse appears in the cycle after the edge that samples the final tick.

The bench drives every strobe just after a rising edge and samples on the following falling edge. Each result is therefore read in exactly the cycle it is due, and a value one cycle early or late counts as a miscompare.

// File: rtl/uart_chan_router_pkg.sv
// Package: shared types, control bit positions and character-length helper
// for the UART channel mode data router.
package uart_chan_router_pkg;

    typedef enum logic [1:0] {
        CM_NORMAL = 2'd0,
        CM_ECHO   = 2'd1,
        CM_LLOOP  = 2'd2,
        CM_RLOOP  = 2'd3
    } chmode_e;

    localparam int CTRL_W    = 9;
    localparam int CB_RXRST  = 0;
    localparam int CB_TXRST  = 1;
    localparam int CB_RXEN   = 2;
    localparam int CB_RXDIS  = 3;
    localparam int CB_TXEN   = 4;
    localparam int CB_TXDIS  = 5;
    localparam logic [CTRL_W-1:0] CTRL_RESET   = 9'h128;
    localparam logic [CTRL_W-1:0] CTRL_SELFCLR = 9'h003;
    localparam int MAX_CHAR_BITS = 12;

    // Number of bit times in one character frame.
    function automatic logic [3:0] char_bits(input logic [1:0] len,
                                             input logic par,
                                             input logic two_stop);
        logic [3:0] d;
        case (len)
            2'b01:   d = 4'd7;
            2'b10:   d = 4'd6;
            default: d = 4'd8;
        endcase
        return 4'd1 + d + {3'b000, par} + (two_stop ? 4'd2 : 4'd1);
    endfunction

endpackage

// File: rtl/chrt_ctrl.sv
// Control register: holds path enable/disable pairs and break bits, turns
// the two reset bits into one-cycle flush pulses and clears them.
// Assumes: a write and its flush effect are one cycle apart.
module chrt_ctrl
    import uart_chan_router_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic              rx_on,
    output logic              tx_on,
    output logic              rx_flush,
    output logic              tx_flush
);

    // Register update with reset bits dropped on store.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
        end else if (ctrl_we) begin
            ctrl_q <= ctrl_wdata & ~CTRL_SELFCLR;
        end
    end

    // One-cycle flush pulses from the self-clearing bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_flush <= 1'b0;
            tx_flush <= 1'b0;
        end else begin
            rx_flush <= ctrl_we & ctrl_wdata[CB_RXRST];
            tx_flush <= ctrl_we & ctrl_wdata[CB_TXRST];
        end
    end

    // Path activity: enable set and disable clear.
    always_comb begin
        rx_on = ctrl_q[CB_RXEN] & ~ctrl_q[CB_RXDIS];
        tx_on = ctrl_q[CB_TXEN] & ~ctrl_q[CB_TXDIS];
    end

    // R5
    selfclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_we |=> (ctrl_q[CB_TXRST:CB_RXRST] == 2'b00));

    // R5
    flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_flush || tx_flush) |-> $past(ctrl_we));

endmodule

// File: rtl/chrt_route.sv
// Steering: decides for each line byte, break and host write which FIFO
// (if any) is pushed, and raises overflow when the target is full.
// Assumes: line_rx_vld and line_brk never coincide; FIFO full flags are
// current for the cycle (pushes are combinational).
module chrt_route
    import uart_chan_router_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        chan_mode,
    input  logic              rx_on,
    input  logic              tx_on,
    input  logic              line_rx_vld,
    input  logic [DATA_W-1:0] line_rx_byte,
    input  logic              line_brk,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              rxf_full,
    input  logic              txf_full,
    output logic              rxf_push,
    output logic [DATA_W-1:0] rxf_wdata,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_wdata,
    output logic              rx_ovr,
    output logic              tx_ovr
);

    chmode_e mode;
    logic    line_to_rx, line_to_tx, host_to_rx, host_to_tx;
    logic    rx_req, tx_req, host_lost;

    // Mode decode into the four candidate routes.
    always_comb begin
        mode       = chmode_e'(chan_mode);
        line_to_rx = line_rx_vld & ((mode == CM_NORMAL) | (mode == CM_ECHO));
        line_to_tx = line_rx_vld & ((mode == CM_ECHO)   | (mode == CM_RLOOP));
        host_to_tx = host_wr & (mode == CM_NORMAL);
        host_to_rx = host_wr & (mode == CM_LLOOP);
    end

    // Receive side: break beats line byte and loopback host byte.
    always_comb begin
        rx_req    = rx_on & (line_brk | line_to_rx | host_to_rx);
        host_lost = rx_on & line_brk & host_to_rx;
        if (line_brk) begin
            rxf_wdata = '0;
        end else if (line_to_rx) begin
            rxf_wdata = line_rx_byte;
        end else begin
            rxf_wdata = host_wdata;
        end
        rxf_push = rx_req & ~rxf_full;
        rx_ovr   = (rx_req & rxf_full) | host_lost;
    end

    // Transmit side: line byte (echo/remote) or host byte (normal).
    always_comb begin
        tx_req    = tx_on & (line_to_tx | host_to_tx);
        txf_wdata = line_to_tx ? line_rx_byte : host_wdata;
        txf_push  = tx_req & ~txf_full;
        tx_ovr    = tx_req & txf_full;
    end

    // R8
    brk_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(line_rx_vld && line_brk));

    // R8
    brk_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (line_brk && rxf_push) |-> (rxf_wdata == '0));

    // R6
    rx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ovr && !line_brk) |-> !rxf_push);

    // R7
    tx_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_ovr |-> !txf_push);

    // R4
    rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rxf_push || rx_ovr) |-> rx_on);

    // R4
    tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (txf_push || tx_ovr) |-> tx_on);

endmodule

// File: rtl/chrt_rdport.sv
// Host read port: pops the receive FIFO on a data-register read and
// registers the returned byte (zero when nothing could be read).
// Assumes: rxf_rdata shows the FIFO head while rxf_empty is 0.
module chrt_rdport #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rd,
    input  logic              rx_on,
    input  logic              rxf_empty,
    input  logic [DATA_W-1:0] rxf_rdata,
    output logic              rxf_pop,
    output logic [DATA_W-1:0] host_rdata
);

    // Pop only when a byte is present and the receiver is active.
    always_comb begin
        rxf_pop = host_rd & rx_on & ~rxf_empty;
    end

    // Capture the head byte, or zero, on every read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (host_rd) begin
            host_rdata <= rxf_pop ? rxf_rdata : '0;
        end
    end

    // R9
    rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && (!rx_on || rxf_empty)) |=> (host_rdata == '0));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> $stable(host_rdata));

endmodule

// File: rtl/chrt_tmo.sv
// Receive timeout: restarted by every accepted receive byte, counts bit
// strobes down from CHARS character times and pulses once on expiry.
// Assumes: bit_tick is a single-cycle strobe per bit time.
module chrt_tmo
    import uart_chan_router_pkg::*;
#(
    parameter int CHARS = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       restart,
    input  logic       bit_tick,
    input  logic [3:0] frame_bits,
    output logic       rx_timeout
);

    localparam int CNT_W = $clog2(CHARS * MAX_CHAR_BITS + 1);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] load;
    logic             armed;

    // Reload value: frame length times the number of characters.
    always_comb begin
        load = CNT_W'(frame_bits) * CNT_W'(CHARS);
    end

    // Countdown with reload priority and single expiry pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt        <= '0;
            armed      <= 1'b0;
            rx_timeout <= 1'b0;
        end else begin
            rx_timeout <= 1'b0;
            if (restart) begin
                cnt   <= load;
                armed <= 1'b1;
            end else if (armed && bit_tick) begin
                if (cnt == CNT_W'(1)) begin
                    armed      <= 1'b0;
                    rx_timeout <= 1'b1;
                end
                cnt <= cnt - CNT_W'(1);
            end
        end
    end

    // R10
    tmo_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_timeout |-> $past(bit_tick));

    // R10
    tmo_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !rx_timeout);

endmodule

// File: rtl/uart_chan_router.sv
// Top: UART channel mode data router. Connects control register,
// steering, host read port and receive timeout.
// Assumes: external FIFOs with full/empty flags and head-data output.
module uart_chan_router
    import uart_chan_router_pkg::*;
#(
    parameter int DATA_W    = 8,
    parameter int TMO_CHARS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    input  logic [1:0]        chan_mode,
    input  logic [1:0]        len_sel,
    input  logic              par_en,
    input  logic              stop2,
    input  logic              line_rx_vld,
    input  logic [DATA_W-1:0] line_rx_byte,
    input  logic              line_brk,
    input  logic              bit_tick,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_rdata,
    output logic              rxf_push,
    output logic [DATA_W-1:0] rxf_wdata,
    input  logic              rxf_full,
    output logic              rxf_pop,
    input  logic [DATA_W-1:0] rxf_rdata,
    input  logic              rxf_empty,
    output logic              rxf_flush,
    output logic              txf_push,
    output logic [DATA_W-1:0] txf_wdata,
    input  logic              txf_full,
    output logic              txf_flush,
    output logic              rx_ovr,
    output logic              tx_ovr,
    output logic              rx_timeout
);

    logic       rx_on, tx_on;
    logic [3:0] frame_bits;

    // Frame length in bit times from the line format selection.
    always_comb begin
        frame_bits = char_bits(len_sel, par_en, stop2);
    end

    chrt_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ctrl_q     (ctrl_q),
        .rx_on      (rx_on),
        .tx_on      (tx_on),
        .rx_flush   (rxf_flush),
        .tx_flush   (txf_flush)
    );

    chrt_route #(.DATA_W(DATA_W)) u_route (
        .clk          (clk),
        .rst_n        (rst_n),
        .chan_mode    (chan_mode),
        .rx_on        (rx_on),
        .tx_on        (tx_on),
        .line_rx_vld  (line_rx_vld),
        .line_rx_byte (line_rx_byte),
        .line_brk     (line_brk),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .rxf_full     (rxf_full),
        .txf_full     (txf_full),
        .rxf_push     (rxf_push),
        .rxf_wdata    (rxf_wdata),
        .txf_push     (txf_push),
        .txf_wdata    (txf_wdata),
        .rx_ovr       (rx_ovr),
        .tx_ovr       (tx_ovr)
    );

    chrt_rdport #(.DATA_W(DATA_W)) u_rdport (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_rd    (host_rd),
        .rx_on      (rx_on),
        .rxf_empty  (rxf_empty),
        .rxf_rdata  (rxf_rdata),
        .rxf_pop    (rxf_pop),
        .host_rdata (host_rdata)
    );

    chrt_tmo #(.CHARS(TMO_CHARS)) u_tmo (
        .clk        (clk),
        .rst_n      (rst_n),
        .restart    (rxf_push),
        .bit_tick   (bit_tick),
        .frame_bits (frame_bits),
        .rx_timeout (rx_timeout)
    );

    // R1
    rst_ctrl_chk: assert property (@(posedge clk)
        $rose(rst_n) |-> (ctrl_q == CTRL_RESET));

endmodule

// File: tb/uart_chan_router_bench.sv
// Scoreboard bench: drive tasks queue expected FIFO pushes, a negedge
// monitor pops and compares them; direct checks cover the rest.
module uart_chan_router_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctrl_we = 1'b0;
    logic [8:0] ctrl_wdata = '0;
    logic [8:0] ctrl_q;
    logic [1:0] chan_mode = 2'd0;
    logic [1:0] len_sel = 2'd0;
    logic       par_en = 1'b0, stop2 = 1'b0;
    logic       line_rx_vld = 1'b0, line_brk = 1'b0, bit_tick = 1'b0;
    logic [7:0] line_rx_byte = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       rxf_push, rxf_pop, rxf_flush, txf_push, txf_flush;
    logic [7:0] rxf_wdata, txf_wdata;
    logic       rxf_full = 1'b0, txf_full = 1'b0, rxf_empty = 1'b1;
    logic [7:0] rxf_rdata = '0;
    logic       rx_ovr, tx_ovr, rx_timeout;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [8:0] expq[$];
    string      reqq[$];

    always #2 clk = ~clk;

    uart_chan_router u_uart_chan_router (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .ctrl_q(ctrl_q), .chan_mode(chan_mode), .len_sel(len_sel),
        .par_en(par_en), .stop2(stop2), .line_rx_vld(line_rx_vld),
        .line_rx_byte(line_rx_byte), .line_brk(line_brk), .bit_tick(bit_tick),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .rxf_push(rxf_push), .rxf_wdata(rxf_wdata),
        .rxf_full(rxf_full), .rxf_pop(rxf_pop), .rxf_rdata(rxf_rdata),
        .rxf_empty(rxf_empty), .rxf_flush(rxf_flush), .txf_push(txf_push),
        .txf_wdata(txf_wdata), .txf_full(txf_full), .txf_flush(txf_flush),
        .rx_ovr(rx_ovr), .tx_ovr(tx_ovr), .rx_timeout(rx_timeout)
    );

    task automatic chk(input string req, input logic [15:0] act,
                       input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // Monitor: every observed push must match the head of the queue.
    task automatic score(input bit is_tx, input logic [7:0] d);
        if (expq.size() == 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R2 actual=unexpected push %0d:%h expected=none",
                     is_tx, d);
        end else begin
            chk(reqq.pop_front(), {7'd0, is_tx, d}, {7'd0, expq.pop_front()});
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (rxf_push) score(1'b0, rxf_wdata);
            if (txf_push) score(1'b1, txf_wdata);
        end
    end

    // kind: 0 line byte, 1 host write, 2 break, 3 break plus host write.
    task automatic drive(input int kind, input logic [7:0] b,
                         input bit er, input bit et, input bit eor,
                         input bit eot, input string req);
        line_rx_vld  = (kind == 0);
        line_rx_byte = b;
        host_wr      = (kind == 1) || (kind == 3);
        host_wdata   = b;
        line_brk     = (kind >= 2);
        if (er) begin
            expq.push_back({1'b0, (kind >= 2) ? 8'h00 : b});
            reqq.push_back(req);
        end
        if (et) begin
            expq.push_back({1'b1, b});
            reqq.push_back(req);
        end
        @(negedge clk);
        chk(req, {14'd0, rxf_push, txf_push}, {14'd0, er, et});
        chk(req, {14'd0, rx_ovr, tx_ovr}, {14'd0, eor, eot});
        step();
        line_rx_vld = 1'b0;
        host_wr     = 1'b0;
        line_brk    = 1'b0;
    endtask

    task automatic wr_ctrl(input logic [8:0] v);
        ctrl_we    = 1'b1;
        ctrl_wdata = v;
        step();
        ctrl_we    = 1'b0;
    endtask

    task automatic rd(input bit ep, input logic [7:0] ed, input string req);
        host_rd = 1'b1;
        @(negedge clk);
        chk(req, {15'd0, rxf_pop}, {15'd0, ep});
        step();
        host_rd = 1'b0;
        @(negedge clk);
        chk(req, {8'd0, host_rdata}, {8'd0, ed});
        step();
    endtask

    task automatic ticks(input int n, output int first);
        first = 0;
        for (int i = 1; i <= n; i++) begin
            bit_tick = 1'b1;
            step();
            bit_tick = 1'b0;
            @(negedge clk);
            if (rx_timeout && first == 0) first = i;
            step();
        end
    endtask

    initial begin
        int f;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        @(negedge clk);
        // R1: reset value and inactive paths
        chk("R1", {7'd0, ctrl_q}, 16'h0128);
        step();
        drive(0, 8'h11, 0, 0, 0, 0, "R1");
        rxf_full = 1'b1; txf_full = 1'b1;
        drive(1, 8'h12, 0, 0, 0, 0, "R1");
        rxf_full = 1'b0; txf_full = 1'b0;

        wr_ctrl(9'h014);
        @(negedge clk);
        chk("R4", {7'd0, ctrl_q}, 16'h0014);
        step();

        // R2 / R3: routing in all four modes
        chan_mode = 2'd0;
        drive(0, 8'hA1, 1, 0, 0, 0, "R2");
        drive(1, 8'hB1, 0, 1, 0, 0, "R3");
        chan_mode = 2'd1;
        drive(0, 8'hA2, 1, 1, 0, 0, "R2");
        drive(1, 8'hB2, 0, 0, 0, 0, "R3");
        chan_mode = 2'd2;
        drive(0, 8'hA3, 0, 0, 0, 0, "R2");
        drive(1, 8'hB3, 1, 0, 0, 0, "R3");
        chan_mode = 2'd3;
        drive(0, 8'hA4, 0, 1, 0, 0, "R2");
        drive(1, 8'hB4, 0, 0, 0, 0, "R3");

        // R4: enable/disable pairs
        chan_mode = 2'd0;
        wr_ctrl(9'h01C);
        drive(0, 8'hC1, 0, 0, 0, 0, "R4");
        drive(1, 8'hC2, 0, 1, 0, 0, "R4");
        wr_ctrl(9'h034);
        drive(1, 8'hC3, 0, 0, 0, 0, "R4");
        drive(0, 8'hC4, 1, 0, 0, 0, "R4");
        wr_ctrl(9'h008);
        rxf_full = 1'b1; txf_full = 1'b1;
        drive(0, 8'hC5, 0, 0, 0, 0, "R4");
        drive(1, 8'hC6, 0, 0, 0, 0, "R4");
        rxf_full = 1'b0; txf_full = 1'b0;

        // R5: self-clearing reset bits
        wr_ctrl(9'h017);
        @(negedge clk);
        chk("R5", {14'd0, rxf_flush, txf_flush}, 16'h0003);
        chk("R5", {7'd0, ctrl_q}, 16'h0014);
        step();
        @(negedge clk);
        chk("R5", {14'd0, rxf_flush, txf_flush}, 16'h0000);
        step();
        wr_ctrl(9'h015);
        @(negedge clk);
        chk("R5", {14'd0, rxf_flush, txf_flush}, 16'h0002);
        step();

        // R6: receive overflow
        rxf_full = 1'b1;
        chan_mode = 2'd0;
        drive(0, 8'hD1, 0, 0, 1, 0, "R6");
        chan_mode = 2'd2;
        drive(1, 8'hD2, 0, 0, 1, 0, "R6");
        rxf_full = 1'b0;

        // R7: transmit overflow
        txf_full = 1'b1;
        chan_mode = 2'd0;
        drive(1, 8'hE1, 0, 0, 0, 1, "R7");
        chan_mode = 2'd3;
        drive(0, 8'hE2, 0, 0, 0, 1, "R7");
        chan_mode = 2'd1;
        drive(0, 8'hE3, 1, 0, 0, 1, "R7");
        txf_full = 1'b0;

        // R8: breaks
        chan_mode = 2'd0;
        drive(2, 8'h00, 1, 0, 0, 0, "R8");
        chan_mode = 2'd3;
        drive(2, 8'h00, 1, 0, 0, 0, "R8");
        chan_mode = 2'd2;
        drive(3, 8'hF1, 1, 0, 1, 0, "R8");

        // R9: host reads
        chan_mode = 2'd0;
        rxf_empty = 1'b0; rxf_rdata = 8'hA5;
        rd(1, 8'hA5, "R9");
        wr_ctrl(9'h01C);
        rd(0, 8'h00, "R9");
        wr_ctrl(9'h014);
        rxf_rdata = 8'h3C;
        rd(1, 8'h3C, "R9");
        rxf_empty = 1'b1;
        rd(0, 8'h00, "R9");

        // R10: timeout, 8N1 frame = 10 bits -> 40 ticks
        len_sel = 2'b00; par_en = 1'b0; stop2 = 1'b0;
        drive(0, 8'h71, 1, 0, 0, 0, "R10");
        ticks(45, f);
        chk("R10", 16'(f), 16'd40);
        // 7 data + parity + 2 stop = 11 bits -> 44 ticks, with a restart
        len_sel = 2'b01; par_en = 1'b1; stop2 = 1'b1;
        drive(0, 8'h72, 1, 0, 0, 0, "R10");
        ticks(20, f);
        chk("R10", 16'(f), 16'd0);
        drive(0, 8'h73, 1, 0, 0, 0, "R10");
        ticks(50, f);
        chk("R10", 16'(f), 16'd44);

        step();
        chk("R2", 16'(expq.size()), 16'd0);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule